// File: doc/BRIEF.md
# Auxiliary Power Reset Sequencer

This block decides, after each fundamental reset of a switch-class device, whether state that is meant to survive fundamental reset must be wiped or kept, and it loads the auxiliary power enable control bit. An external power-on circuit sequences an active-low auxiliary power disable input against the fundamental reset. The block synchronizes that input through two flops and samples it at two fixed points after reset is released. At the first point it learns whether the device was parked in L2. At the second point it learns whether auxiliary power use is allowed at all.

Alongside this, the block tracks a four-valued power state from the main and auxiliary power-good inputs and from the L2 enable condition. L2 is enabled when both the auxiliary power detected bit and the PME enable bit are 1. When main power drops while L2 is enabled, the block enters active standby. There it requests a save of the surviving state and powers the wake and beacon logic. Otherwise it falls into inactive standby, where neither happens.

Top module: `auxpwr_rst_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sticky_clr`, `sticky_save`, `wake_en` and `aux_en` are 0 and `pwr_state` is 2'b00 (off).
- R2: Count clock edges at which `fund_rst_n` is sampled high since it was last sampled low. At the 8th such edge, if the synchronized `aux_dis_n` is 0, `sticky_clr` is 1 for exactly the one following cycle.
- R3: If the synchronized `aux_dis_n` is 1 at that 8th edge, `sticky_clr` stays 0.
- R4: At the 256th such edge, `aux_en` is loaded with the synchronized `aux_dis_n` (0 means L2 disabled, 1 means enabled). At all other edges `aux_en` holds its value.
- R5: `fund_rst_n` sampled low restarts the count from zero, so a release shorter than 8 edges produces no sample. The count saturates after the 256th edge: no further sample occurs until `fund_rst_n` is low again, and none occurs after `rst` until a first low.
- R6: `aux_det` always equals `aux_en`. `l2_ok` is 1 exactly when `aux_det` and `pme_en` are both 1.
- R7: `pwr_state` encodes off=2'b00, inactive standby=2'b01, active standby=2'b10, on=2'b11. One edge after `main_pg` is sampled 1 it is on. One edge after both power-goods are sampled 0 it is off.
- R8: From on, with `main_pg` 0, `aux_pg` 1 and `l2_ok` 1 at an edge, the state becomes active standby. `sticky_save` is 1 for exactly the first cycle in active standby, and `wake_en` is 1 exactly while in active standby.
- R9: With main power absent, auxiliary power present and the L2 entry condition not met, the state is inactive standby, with `wake_en` 0 and no `sticky_save` pulse.
- R10: Active standby persists while `main_pg` is 0 and `aux_pg` is 1, without repeating `sticky_save`. It leaves to on when main power returns and to off when auxiliary power is lost.
- R11: `aux_dis_n` passes through two flops, so the sample taken at an edge sees the input as it was two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| fund_rst_n | input | 1 | Fundamental reset, active low, synchronous to clk |
| aux_dis_n | input | 1 | Auxiliary power disable, active low, asynchronous |
| main_pg | input | 1 | Main power good |
| aux_pg | input | 1 | Auxiliary power good |
| pme_en | input | 1 | PME enable control bit |
| sticky_clr | output | 1 | One-cycle strobe: clear fundamental-reset-surviving state |
| sticky_save | output | 1 | One-cycle strobe: save surviving state on active standby entry |
| wake_en | output | 1 | Power enable for wake and beacon logic |
| aux_en | output | 1 | Auxiliary power enable control bit |
| aux_det | output | 1 | Auxiliary power detected status bit |
| l2_ok | output | 1 | L2 mode enabled |
| pwr_state | output | 2 | Power state |

## Verification
The clear strobe of the 8th-edge sample and the save strobe on active standby entry can fall in the same cycle. The enable bit from an earlier release stays valid during a new fundamental reset, and that makes L2 entry possible at that moment. The bench provokes the collision by holding the device on with L2 enabled and the disable input low. It then releases fundamental reset and drops main power so that the state change and the 8th edge coincide. It expects both strobes high in the same following cycle, and the per-cycle reference model confirms that each strobe lasts one cycle.

// File: rtl/auxpwr_pkg.sv
package auxpwr_pkg;

    typedef enum logic [1:0] {
        PWR_OFF   = 2'b00,
        PWR_INACT = 2'b01,
        PWR_ACT   = 2'b10,
        PWR_ON    = 2'b11
    } pwr_e;

    typedef struct packed {
        logic early;   // L2-history sample point
        logic late;    // enable-load sample point
    } samp_t;

    function automatic pwr_e pwr_next(pwr_e cur, logic main_ok, logic aux_ok, logic l2);
        pwr_e n;
        if (main_ok)
            n = PWR_ON;
        else if (!aux_ok)
            n = PWR_OFF;
        else if (cur == PWR_ACT)
            n = PWR_ACT;
        else if (cur == PWR_ON && l2)
            n = PWR_ACT;
        else
            n = PWR_INACT;
        return n;
    endfunction

endpackage

// File: rtl/auxpwr_sync.sv
module auxpwr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= {STAGES{RST_VAL}};
        else
            sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/auxpwr_rel_timer.sv
module auxpwr_rel_timer
    import auxpwr_pkg::*;
#(
    parameter int CLR_SAMPLE = 8,
    parameter int EN_SAMPLE  = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fund_rst_n,
    output samp_t stb
);
    localparam int CNT_W = $clog2(EN_SAMPLE + 1);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(EN_SAMPLE);
    localparam logic [CNT_W-1:0] CNT_EARLY = CNT_W'(CLR_SAMPLE - 1);
    localparam logic [CNT_W-1:0] CNT_LATE  = CNT_W'(EN_SAMPLE - 1);

    logic [CNT_W-1:0] cnt;

    // Saturated after block reset: nothing is sampled until a first low.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_SAT;
        else if (!fund_rst_n)
            cnt <= '0;
        else if (cnt != CNT_SAT)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        stb.early = fund_rst_n && (cnt == CNT_EARLY);
        stb.late  = fund_rst_n && (cnt == CNT_LATE);
    end
endmodule

// File: rtl/auxpwr_pwr_fsm.sv
module auxpwr_pwr_fsm
    import auxpwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic main_pg,
    input  logic aux_pg,
    input  logic l2_ok,
    output pwr_e state,
    output logic save_stb,
    output logic wake
);
    pwr_e nxt;

    always_comb nxt = pwr_next(state, main_pg, aux_pg, l2_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PWR_OFF;
            save_stb <= 1'b0;
            wake     <= 1'b0;
        end else begin
            state    <= nxt;
            save_stb <= (nxt == PWR_ACT) && (state != PWR_ACT);
            wake     <= (nxt == PWR_ACT);
        end
    end
endmodule

// File: rtl/auxpwr_rst_seq.sv
module auxpwr_rst_seq
    import auxpwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CLR_SAMPLE  = 8,
    parameter int EN_SAMPLE   = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fund_rst_n,
    input  logic       aux_dis_n,
    input  logic       main_pg,
    input  logic       aux_pg,
    input  logic       pme_en,
    output logic       sticky_clr,
    output logic       sticky_save,
    output logic       wake_en,
    output logic       aux_en,
    output logic       aux_det,
    output logic       l2_ok,
    output logic [1:0] pwr_state
);
    logic  aux_s;
    samp_t stb;
    pwr_e  st;

    auxpwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (aux_dis_n),
        .q   (aux_s)
    );

    auxpwr_rel_timer #(.CLR_SAMPLE(CLR_SAMPLE), .EN_SAMPLE(EN_SAMPLE)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .fund_rst_n (fund_rst_n),
        .stb        (stb)
    );

    // Early sample: input low means no L2 history, so wipe surviving state.
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_clr <= 1'b0;
            aux_en     <= 1'b0;
        end else begin
            sticky_clr <= stb.early && !aux_s;
            if (stb.late)
                aux_en <= aux_s;
        end
    end

    assign aux_det = aux_en;
    assign l2_ok   = aux_det & pme_en;

    auxpwr_pwr_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .main_pg  (main_pg),
        .aux_pg   (aux_pg),
        .l2_ok    (l2_ok),
        .state    (st),
        .save_stb (sticky_save),
        .wake     (wake_en)
    );

    assign pwr_state = st;
endmodule

// File: rtl/auxpwr_rst_seq_chk.sv
module auxpwr_rst_seq_chk
    import auxpwr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fund_rst_n,
    input logic       main_pg,
    input logic       aux_pg,
    input logic       pme_en,
    input logic       sticky_clr,
    input logic       sticky_save,
    input logic       wake_en,
    input logic       aux_en,
    input logic       l2_ok,
    input logic [1:0] pwr_state
);
    assert_clr_single_R2: assert property (@(posedge clk) disable iff (rst)
        sticky_clr |=> !sticky_clr);

    assert_auxen_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !fund_rst_n |=> $stable(aux_en));

    assert_no_clr_held_R5: assert property (@(posedge clk) disable iff (rst)
        !fund_rst_n |=> !sticky_clr);

    assert_l2_needs_pme_R6: assert property (@(posedge clk) disable iff (rst)
        l2_ok |-> pme_en);

    assert_on_main_R7: assert property (@(posedge clk) disable iff (rst)
        main_pg |=> (pwr_state == PWR_ON));

    assert_off_none_R7: assert property (@(posedge clk) disable iff (rst)
        (!main_pg && !aux_pg) |=> (pwr_state == PWR_OFF));

    assert_act_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_ON && !main_pg && aux_pg && l2_ok) |=> (pwr_state == PWR_ACT));

    assert_save_in_act_R8: assert property (@(posedge clk) disable iff (rst)
        sticky_save |-> (pwr_state == PWR_ACT && wake_en));

    assert_save_single_R8: assert property (@(posedge clk) disable iff (rst)
        sticky_save |=> !sticky_save);

    assert_inact_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_INACT) |-> (!wake_en && !sticky_save));

    assert_act_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_ACT && !main_pg && aux_pg) |=> (pwr_state == PWR_ACT));
endmodule

bind auxpwr_rst_seq auxpwr_rst_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fund_rst_n  (fund_rst_n),
    .main_pg     (main_pg),
    .aux_pg      (aux_pg),
    .pme_en      (pme_en),
    .sticky_clr  (sticky_clr),
    .sticky_save (sticky_save),
    .wake_en     (wake_en),
    .aux_en      (aux_en),
    .l2_ok       (l2_ok),
    .pwr_state   (pwr_state)
);

// File: tb/auxpwr_rst_seq_test.sv
`timescale 1ns/1ps
module auxpwr_rst_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fund_rst_n = 1'b1;
    logic       aux_dis_n = 1'b1;
    logic       main_pg = 1'b0;
    logic       aux_pg = 1'b0;
    logic       pme_en = 1'b0;
    logic       sticky_clr, sticky_save, wake_en, aux_en, aux_det, l2_ok;
    logic [1:0] pwr_state;

    always #2.5 clk = ~clk;

    auxpwr_rst_seq uut (
        .clk(clk), .rst(rst), .fund_rst_n(fund_rst_n), .aux_dis_n(aux_dis_n),
        .main_pg(main_pg), .aux_pg(aux_pg), .pme_en(pme_en),
        .sticky_clr(sticky_clr), .sticky_save(sticky_save), .wake_en(wake_en),
        .aux_en(aux_en), .aux_det(aux_det), .l2_ok(l2_ok), .pwr_state(pwr_state)
    );

    int total = 0;
    int bad = 0;
    int clr_seen = 0;
    int save_seen = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_cnt = 256;
    int m_state = 0;
    bit m_clr = 0, m_save = 0, m_wake = 0, m_auxen = 0;
    bit hist[$] = '{1'b0, 1'b0};

    task automatic model_step();
        bit s;
        bit l2;
        int nx;
        if (rst) begin
            m_cnt = 256; m_state = 0;
            m_clr = 0; m_save = 0; m_wake = 0; m_auxen = 0;
            hist = '{1'b0, 1'b0};
        end else begin
            s  = hist[0];
            l2 = m_auxen && pme_en;
            m_clr = fund_rst_n && (m_cnt == 7) && !s;
            if (fund_rst_n && m_cnt == 255) m_auxen = s;
            if (!fund_rst_n) m_cnt = 0;
            else if (m_cnt < 256) m_cnt++;
            if (main_pg) nx = 3;
            else if (!aux_pg) nx = 0;
            else if (m_state == 2) nx = 2;
            else if (m_state == 3 && l2) nx = 2;
            else nx = 1;
            m_save = (nx == 2) && (m_state != 2);
            m_wake = (nx == 2);
            m_state = nx;
            hist.push_back(aux_dis_n);
            void'(hist.pop_front());
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #1;
        chk("R2 sticky_clr", sticky_clr, m_clr);
        chk("R8 sticky_save", sticky_save, m_save);
        chk("R9 wake_en", wake_en, m_wake);
        chk("R4 aux_en", aux_en, m_auxen);
        chk("R6 aux_det", aux_det, m_auxen);
        chk("R6 l2_ok", l2_ok, m_auxen && pme_en);
        chk("R7 pwr_state", pwr_state, m_state);
        if (sticky_clr) clr_seen++;
        if (sticky_save) save_seen++;
    end

    task automatic finish_up();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic fund_pulse(int low_cycles);
        fund_rst_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        fund_rst_n = 1'b1;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        wait_n(3);
        // R1: reset state
        chk("R1 clr", sticky_clr, 0);
        chk("R1 save", sticky_save, 0);
        chk("R1 wake", wake_en, 0);
        chk("R1 aux_en", aux_en, 0);
        chk("R1 state", pwr_state, 0);
        rst = 1'b0;
        wait_n(1);
        chk("R1 state after release", pwr_state, 0);
        // R5: no sample after rst without a fundamental reset low
        wait_n(300);
        chk("R5 no sample after rst", clr_seen, 0);

        // R2: disable input low at the early point
        aux_dis_n = 1'b0;
        clr_seen = 0;
        fund_pulse(4);
        wait_n(300);
        chk("R2 clr pulses", clr_seen, 1);
        chk("R4 aux_en from low", aux_en, 0);

        // R3: disable input high
        aux_dis_n = 1'b1;
        clr_seen = 0;
        fund_pulse(4);
        wait_n(300);
        chk("R3 clr pulses", clr_seen, 0);
        chk("R4 aux_en from high", aux_en, 1);

        // Power states
        pme_en = 1'b1;
        save_seen = 0;
        aux_pg = 1'b1;
        wait_n(3);
        chk("R7 inactive", pwr_state, 1);
        chk("R9 wake off", wake_en, 0);
        chk("R9 no save", save_seen, 0);
        main_pg = 1'b1;
        wait_n(3);
        chk("R7 on", pwr_state, 3);
        chk("R6 l2_ok", l2_ok, 1);
        chk("R6 aux_det", aux_det, 1);
        main_pg = 1'b0;
        wait_n(3);
        chk("R8 active", pwr_state, 2);
        chk("R8 save once", save_seen, 1);
        chk("R8 wake on", wake_en, 1);
        wait_n(20);
        chk("R10 stays active", pwr_state, 2);
        chk("R10 no repeat save", save_seen, 1);
        main_pg = 1'b1;
        wait_n(3);
        chk("R10 back on", pwr_state, 3);
        main_pg = 1'b0;
        wait_n(3);
        aux_pg = 1'b0;
        wait_n(3);
        chk("R10 to off", pwr_state, 0);
        chk("R10 wake off", wake_en, 0);
        aux_pg = 1'b1;
        main_pg = 1'b1;
        wait_n(3);
        pme_en = 1'b0;
        wait_n(1);
        chk("R6 l2 off without pme", l2_ok, 0);
        save_seen = 0;
        main_pg = 1'b0;
        wait_n(3);
        chk("R9 inactive without l2", pwr_state, 1);
        chk("R9 wake stays off", wake_en, 0);
        chk("R9 no save", save_seen, 0);

        // Collision: clear strobe and save strobe in the same cycle
        pme_en = 1'b1;
        main_pg = 1'b1;
        wait_n(3);
        aux_dis_n = 1'b0;
        fund_pulse(3);
        wait_n(7);
        main_pg = 1'b0;
        @(posedge clk);
        #1;
        chk("R2 clr at collision", sticky_clr, 1);
        chk("R8 save at collision", sticky_save, 1);
        wait_n(300);
        chk("R4 aux_en reloaded low", aux_en, 0);

        // R5: short release aborts, then saturation
        main_pg = 1'b1;
        clr_seen = 0;
        fund_pulse(3);
        wait_n(5);
        fund_pulse(3);
        wait_n(4);
        fund_rst_n = 1'b0;
        wait_n(2);
        chk("R5 aborted releases", clr_seen, 0);
        fund_rst_n = 1'b1;
        wait_n(300);
        chk("R5 full release", clr_seen, 1);
        aux_dis_n = 1'b1;
        wait_n(300);
        chk("R5 saturated aux_en", aux_en, 0);

        // R11: change two edges before the early point is not seen
        clr_seen = 0;
        fund_pulse(4);
        wait_n(6);
        aux_dis_n = 1'b0;
        wait_n(300);
        chk("R11 late change unseen", clr_seen, 0);
        chk("R11 enable sees low", aux_en, 0);

        wait_n(5);
        finish_up();
    end
endmodule